// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, for each received frame, whether the frame should be kept. The decision rests on the frame's 48-bit destination address. The receive path presents the address together with a one-cycle valid strobe. The block compares the address with the programmed station address. It also recognises broadcast and multicast addresses, and it looks up multicast addresses in a 64-bit hash table. A 2-bit strictness setting then turns these facts into a single accept decision.

One cycle after the strobe, the accept decision and four classification flags are available in registers. They stay unchanged until the next strobe, so they can be merged into the frame's receive status word. A separate status bit captures the hash-table lookup result for each frame, but only while receive DMA is enabled.

Top module: `dst_addr_filter`

## Requirements
- R1: With mode 2'b00, `accept_o` is 1 exactly when the destination address equals `station_addr_i`.
- R2: With mode 2'b01, `accept_o` is 1 when any of these holds: the station address matches, the address is broadcast, or the address is multicast and hits the hash table.
- R3: With mode 2'b10, `accept_o` is 1 when the station address matches or the address is multicast. Broadcast counts as multicast.
- R4: With mode 2'b11, `accept_o` is 1 for every address.
- R5: `station_hit_o` is 1 exactly when all 48 bits of `dst_addr_i` equal `station_addr_i`.
- R6: The first address byte is `dst_addr_i[7:0]`. `mcast_o` is 1 when `dst_addr_i[0]` is 1. `bcast_o` is 1 when all 48 bits are 1, and a broadcast address also sets `mcast_o`.
- R7: The hash index is computed with CRC-32 (reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF, no final inversion). The CRC runs over `dst_addr_i` bit 0 first through bit 47. The index is bits [31:26] of the resulting register. `hash_hit_o` is `hash_table_i[index]` AND the multicast condition.
- R8: On a strobe with `rx_dma_en_i` = 1, `hash_latch_o` takes the strobe's `hash_hit_o` value. Otherwise it holds its value.
- R9: All outputs reset to 0. They update only on the clock edge where `addr_valid_i` is 1, and they hold between strobes even if the address, mode, station address or table change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Destination address strobe |
| dst_addr_i | input | 48 | Destination address, first byte in [7:0] |
| mode_i | input | 2 | Filter strictness |
| station_addr_i | input | 48 | Programmed station address |
| hash_table_i | input | 64 | Multicast hash filter table |
| rx_dma_en_i | input | 1 | Receive DMA enabled, gates the hash status latch |
| accept_o | output | 1 | Frame accepted |
| station_hit_o | output | 1 | Station address matched |
| hash_hit_o | output | 1 | Multicast hash filter hit |
| bcast_o | output | 1 | Broadcast frame |
| mcast_o | output | 1 | Multicast-class frame |
| hash_latch_o | output | 1 | Latched hash select status |

## Verification
A corrupted hash index sends multicast frames to the wrong table bit. The error shows on `hash_hit_o` in the cycle after the first multicast strobe whose wrong bit differs from the right one. Under mode 2'b01 it also shows on `accept_o`. A bad hold condition changes an output between strobes, and the bench compares every cycle, so that shows on the very next edge. A wrong mode decode flips `accept_o` on the first strobe that falls in the affected mode and address class.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;
  localparam int unsigned ADDR_W   = 48;
  localparam int unsigned HASH_W   = 6;
  localparam int unsigned TABLE_SZ = 1 << HASH_W;

  typedef enum logic [1:0] {
    FLT_STATION = 2'b00,
    FLT_HASH_MC = 2'b01,
    FLT_ALL_MC  = 2'b10,
    FLT_PROMISC = 2'b11
  } flt_mode_e;

  typedef struct packed {
    logic stn;
    logic bcast;
    logic mcast;
    logic hash;
  } flt_flags_t;
endpackage

// File: rtl/addr_classify.sv
module addr_classify
  import dst_filt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] station_i,
  output logic          stn_o,
  output logic          bcast_o,
  output logic          mcast_o
);
  always_comb begin
    stn_o   = (addr_i == station_i);
    bcast_o = &addr_i;
    mcast_o = addr_i[0];
  end
endmodule

// File: rtl/mcast_hash.sv
module mcast_hash
  import dst_filt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned HW = HASH_W,
  localparam int unsigned TW = 1 << HW
) (
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] table_i,
  output logic [HW-1:0] idx_o,
  output logic          bit_o
);
  logic [31:0] crc;

  // serial reflected CRC-32, LSB of the address first
  always_comb begin
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < int'(AW); i++) begin
      if (crc[0] ^ addr_i[i]) crc = (crc >> 1) ^ 32'hEDB8_8320;
      else                    crc = crc >> 1;
    end
    idx_o = crc[31 -: HW];
    bit_o = table_i[idx_o];
  end
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dst_filt_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned HW = HASH_W,
  localparam int unsigned TW = 1 << HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_valid_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] station_addr_i,
  input  logic [TW-1:0] hash_table_i,
  input  logic          rx_dma_en_i,
  output logic          accept_o,
  output logic          station_hit_o,
  output logic          hash_hit_o,
  output logic          bcast_o,
  output logic          mcast_o,
  output logic          hash_latch_o
);
  logic          stn_c, bc_c, mc_c, tbl_bit;
  logic [HW-1:0] idx;
  flt_flags_t    flg_c, flg_q;
  logic          acc_c, acc_q, latch_q;
  flt_mode_e     mode;

  addr_classify #(.AW(AW)) u_cls (
    .addr_i   (dst_addr_i),
    .station_i(station_addr_i),
    .stn_o    (stn_c),
    .bcast_o  (bc_c),
    .mcast_o  (mc_c)
  );

  mcast_hash #(.AW(AW), .HW(HW)) u_hash (
    .addr_i (dst_addr_i),
    .table_i(hash_table_i),
    .idx_o  (idx),
    .bit_o  (tbl_bit)
  );

  always_comb begin
    mode  = flt_mode_e'(mode_i);
    flg_c = '{stn: stn_c, bcast: bc_c, mcast: mc_c, hash: mc_c & tbl_bit};
    unique case (mode)
      FLT_STATION: acc_c = flg_c.stn;
      FLT_HASH_MC: acc_c = flg_c.stn | flg_c.bcast | flg_c.hash;
      FLT_ALL_MC:  acc_c = flg_c.stn | flg_c.mcast;
      default:     acc_c = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q   <= '0;
      acc_q   <= 1'b0;
      latch_q <= 1'b0;
    end else if (addr_valid_i) begin
      flg_q <= flg_c;
      acc_q <= acc_c;
      if (rx_dma_en_i) latch_q <= flg_c.hash;
    end
  end

  assign accept_o      = acc_q;
  assign station_hit_o = flg_q.stn;
  assign hash_hit_o    = flg_q.hash;
  assign bcast_o       = flg_q.bcast;
  assign mcast_o       = flg_q.mcast;
  assign hash_latch_o  = latch_q;

  p_station_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i && mode_i == 2'b00 |=> accept_o == $past(stn_c));
  p_hash_mode_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i && mode_i == 2'b01 && mc_c && tbl_bit |=> accept_o);
  p_all_mcast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i && mode_i == 2'b10 && mc_c |=> accept_o);
  p_promisc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_i && mode_i == 2'b11 |=> accept_o);
  p_bcast_is_mcast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> mcast_o);
  p_hash_needs_mcast_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_hit_o |-> mcast_o);
  p_latch_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_valid_i && rx_dma_en_i) |=> $stable(hash_latch_o));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_valid_i |=> $stable({accept_o, station_hit_o, hash_hit_o, bcast_o, mcast_o}));
endmodule

// File: tb/tb_dst_addr_filter.sv
module tb_dst_addr_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [47:0] da = '0;
  logic [1:0]  mode = '0;
  logic [47:0] stn = 48'h5634_1200_AB02;
  logic [63:0] tbl = '0;
  logic        dma = 1'b0;
  logic        acc, shit, hhit, bc, mc, hl;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // expected outputs, reset values zero (R9)
  bit e_acc, e_stn, e_hash, e_bc, e_mc, e_hl;

  always #2 clk = ~clk;

  dst_addr_filter dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_valid_i(vld), .dst_addr_i(da),
    .mode_i(mode), .station_addr_i(stn), .hash_table_i(tbl), .rx_dma_en_i(dma),
    .accept_o(acc), .station_hit_o(shit), .hash_hit_o(hhit), .bcast_o(bc),
    .mcast_o(mc), .hash_latch_o(hl)
  );

  function automatic bit [5:0] ref_idx(input bit [47:0] a);
    int unsigned c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++) begin
      c = c ^ int'(a[8*b +: 8]);
      for (int k = 0; k < 8; k++) c = (c & 1) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  task automatic chk(input string tag, input bit act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  bit [1:0] e_mode;

  task automatic compare_all();
    string mt;
    case (e_mode)
      2'd0: mt = "R1 accept";
      2'd1: mt = "R2 accept";
      2'd2: mt = "R3 accept";
      default: mt = "R4 accept";
    endcase
    chk(mt, acc, e_acc);
    chk("R5 station_hit", shit, e_stn);
    chk("R6 bcast", bc, e_bc);
    chk("R6 mcast", mc, e_mc);
    chk("R7 hash_hit", hhit, e_hash);
    chk("R8 hash_latch", hl, e_hl);
  endtask

  task automatic predict();
    bit s, b, m, h;
    s = (da == stn);
    b = (da == {48{1'b1}});
    m = da[0] | b;
    h = m && tbl[ref_idx(da)];
    e_stn = s; e_bc = b; e_mc = m; e_hash = h; e_mode = mode;
    case (mode)
      2'd0: e_acc = s;
      2'd1: e_acc = s || b || h;
      2'd2: e_acc = s || m;
      default: e_acc = 1'b1;
    endcase
    if (dma) e_hl = h;
  endtask

  task automatic pick(input int kind);
    case (kind)
      0: da = stn;
      1: da = {48{1'b1}};
      2: da = {$urandom(), $urandom()} | 48'h1;
      3: da = {$urandom(), $urandom()} & ~48'h1;
      default: da = {stn[47:1], 1'b0} ^ (48'h1 << (1 + $urandom_range(0, 46)));
    endcase
    if (da[0] && $urandom_range(0, 1) == 1) tbl[ref_idx(da)] = 1'b1;
    if ($urandom_range(0, 7) == 0) tbl[ref_idx(da)] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all();  // R9 reset values
    rst_n = 1'b1;
    tbl = 64'h0123_4567_89AB_CDEF;
    // directed: every mode against every address class, DMA on
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        compare_all();
        mode = md[1:0]; dma = 1'b1; vld = 1'b1;
        pick(k);
        predict();
      end
    end
    // random: strobes interleaved with idle cycles whose inputs still wiggle (R9)
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      compare_all();
      mode = 2'($urandom_range(0, 3));
      dma  = ($urandom_range(0, 3) != 0);
      vld  = ($urandom_range(0, 9) < 6);
      pick($urandom_range(0, 4));
      if (vld) predict();
    end
    @(negedge clk);
    compare_all();
    vld = 1'b0;
    @(negedge clk);
    compare_all();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule